// File: doc/BRIEF.md
# Synthesiser divider chain

This block holds the two counters that sit in front of a phase comparator in a frequency synthesiser loop. The reference divider runs on the crystal clock and divides it by a ratio chosen by a 2-bit mode input, producing a one-cycle comparison pulse once per reference period. The feedback divider runs on the already-prescaled RF clock and divides it by a programmed divisor word, producing a one-cycle feedback pulse once per feedback period.

The same mode input picks both the reference ratio (512, 640 or 1024) and the width of the divisor honoured by the feedback divider (14 or 15 bits). With a nominal 4 MHz crystal and a divide-by-16 prescaler ahead of the feedback divider, the loop step becomes 125 kHz, 100 kHz or 62.5 kHz. Each counter reloads only at its own terminal count, so a change of mode or divisor never cuts a period short. A divisor below two is raised to two so the feedback output keeps running.

Top module: `synth_div_chain`

## Requirements
- R1: With mode value 3 or 2, cmp_pulse is high for exactly one ref_clk cycle in every 512.
- R2: With mode value 1 the comparison period is 1024 ref_clk cycles; with mode value 0 it is 640.
- R3: With mode value 0, 1 or 2, fb_pulse recurs every N fb_clk cycles, where N is the full 15-bit divisor.
- R4: With mode value 3, divisor bit 14 is ignored: the feedback period equals the value of divisor bits 13..0.
- R5: A divisor (after the bit-14 masking of R4) of 0 or 1 gives a feedback period of 2 fb_clk cycles.
- R6: Mode and divisor are sampled only on the clock edge that raises the counter's pulse; a change at any other time takes effect at the next pulse and the period in progress completes at its old length.
- R7: cmp_pulse and fb_pulse are never high on two consecutive cycles of their own clock.
- R8: While rst_n is low both pulses are low; the first rising edge of each clock after rst_n goes high raises that clock's pulse and starts a period with the mode and divisor present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Crystal reference clock |
| fb_clk | input | 1 | Prescaled RF clock feeding the feedback divider |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| mode | input | 2 | Mode select: 3 = 512 / 14-bit, 2 = 512 / 15-bit, 1 = 1024 / 15-bit, 0 = 640 / 15-bit |
| divisor | input | 15 | Feedback divide value |
| cmp_pulse | output | 1 | One-cycle comparison pulse in the ref_clk domain |
| fb_pulse | output | 1 | One-cycle feedback pulse in the fb_clk domain |

## Verification
The bound checker watches, every cycle, that the gap between consecutive pulses in each domain equals the period latched at the earlier pulse, that the latched periods only move on a pulse edge, that the reference period is one of the legal ratios, that the feedback period never falls below two, and that neither pulse lasts more than one cycle. Which ratio a given mode code selects, that bit 14 is dropped only in mode 3, and that a mid-period change of inputs is deferred exactly to the next terminal count are shown only by the bench scenarios, where a behavioural model of pulse timing is compared against both outputs on every edge of both clocks.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    // Mode codes as seen on the 2-bit mode input.
    typedef enum logic [1:0] {
        MODE_R640  = 2'd0,
        MODE_R1024 = 2'd1,
        MODE_R512W = 2'd2,
        MODE_R512N = 2'd3
    } div_mode_e;

endpackage

// File: rtl/sdc_ref_divider.sv
module sdc_ref_divider
    import synth_div_pkg::*;
#(
    parameter int RATIO_M0 = 640,
    parameter int RATIO_M1 = 1024,
    parameter int RATIO_M2 = 512,
    parameter int RATIO_M3 = 512,
    parameter int REF_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    output logic             pulse,
    output logic [REF_W-1:0] period
);

    typedef struct packed {
        logic [REF_W-1:0] cnt;
        logic [REF_W-1:0] period;
        logic             pulse;
    } ref_state_t;

    ref_state_t       st_q, st_d;
    logic [REF_W-1:0] sel_ratio;

    // Ratio picked by the mode code.
    always_comb begin
        case (div_mode_e'(mode))
            MODE_R640:  sel_ratio = REF_W'(RATIO_M0);
            MODE_R1024: sel_ratio = REF_W'(RATIO_M1);
            MODE_R512W: sel_ratio = REF_W'(RATIO_M2);
            MODE_R512N: sel_ratio = REF_W'(RATIO_M3);
            default:    sel_ratio = REF_W'(RATIO_M3);
        endcase
    end

    // Down-count to zero; zero is the terminal count and the reload point.
    always_comb begin
        st_d       = st_q;
        st_d.pulse = (st_q.cnt == '0);
        if (st_q.cnt == '0) begin
            st_d.cnt    = sel_ratio - REF_W'(1);
            st_d.period = sel_ratio;
        end else begin
            st_d.cnt = st_q.cnt - REF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse  = st_q.pulse;
    assign period = st_q.period;

endmodule

// File: rtl/sdc_fb_divider.sv
module sdc_fb_divider
    import synth_div_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int NARROW_W = 14,
    parameter int MIN_DIV  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] divisor,
    output logic             pulse,
    output logic [DIV_W-1:0] period
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] period;
        logic             pulse;
    } fb_state_t;

    fb_state_t        st_q, st_d;
    logic [DIV_W-1:0] keep_mask;
    logic [DIV_W-1:0] masked_div;
    logic [DIV_W-1:0] eff_div;
    logic             narrow;

    assign narrow = (div_mode_e'(mode) == MODE_R512N);

    // Bits at or above NARROW_W are dropped in the narrow mode.
    generate
        for (genvar b = 0; b < DIV_W; b++) begin : g_mask
            if (b < NARROW_W) begin : g_low
                assign keep_mask[b] = 1'b1;
            end else begin : g_high
                assign keep_mask[b] = ~narrow;
            end
        end
    endgenerate

    always_comb begin
        masked_div = divisor & keep_mask;
        eff_div    = (masked_div < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : masked_div;
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = (st_q.cnt == '0);
        if (st_q.cnt == '0) begin
            st_d.cnt    = eff_div - DIV_W'(1);
            st_d.period = eff_div;
        end else begin
            st_d.cnt = st_q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse  = st_q.pulse;
    assign period = st_q.period;

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain #(
    parameter int RATIO_M0 = 640,
    parameter int RATIO_M1 = 1024,
    parameter int RATIO_M2 = 512,
    parameter int RATIO_M3 = 512,
    parameter int DIV_W    = 15,
    parameter int NARROW_W = 14,
    parameter int MIN_DIV  = 2
) (
    input  logic             ref_clk,
    input  logic             fb_clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] divisor,
    output logic             cmp_pulse,
    output logic             fb_pulse
);

    localparam int RMAX_A = (RATIO_M0 > RATIO_M1) ? RATIO_M0 : RATIO_M1;
    localparam int RMAX_B = (RATIO_M2 > RATIO_M3) ? RATIO_M2 : RATIO_M3;
    localparam int RMAX   = (RMAX_A > RMAX_B) ? RMAX_A : RMAX_B;
    localparam int REF_W  = $clog2(RMAX + 1);

    logic [REF_W-1:0] ref_period_w;
    logic [DIV_W-1:0] fb_period_w;

    sdc_ref_divider #(
        .RATIO_M0 (RATIO_M0),
        .RATIO_M1 (RATIO_M1),
        .RATIO_M2 (RATIO_M2),
        .RATIO_M3 (RATIO_M3),
        .REF_W    (REF_W)
    ) u_ref (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .pulse  (cmp_pulse),
        .period (ref_period_w)
    );

    sdc_fb_divider #(
        .DIV_W    (DIV_W),
        .NARROW_W (NARROW_W),
        .MIN_DIV  (MIN_DIV)
    ) u_fb (
        .clk     (fb_clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .divisor (divisor),
        .pulse   (fb_pulse),
        .period  (fb_period_w)
    );

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
    parameter int RATIO_M0 = 640,
    parameter int RATIO_M1 = 1024,
    parameter int RATIO_M2 = 512,
    parameter int RATIO_M3 = 512,
    parameter int REF_W    = 11,
    parameter int DIV_W    = 15,
    parameter int MIN_DIV  = 2
) (
    input logic             ref_clk,
    input logic             fb_clk,
    input logic             rst_n,
    input logic             cmp_pulse,
    input logic             fb_pulse,
    input logic [REF_W-1:0] ref_period,
    input logic [DIV_W-1:0] fb_period
);

    logic [31:0] ref_gap_q, ref_last_q, fb_gap_q, fb_last_q;
    logic        ref_armed_q, fb_armed_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_gap_q   <= '0;
            ref_last_q  <= '0;
            ref_armed_q <= 1'b0;
        end else if (cmp_pulse) begin
            ref_gap_q   <= 32'd1;
            ref_last_q  <= 32'(ref_period);
            ref_armed_q <= 1'b1;
        end else begin
            ref_gap_q <= ref_gap_q + 32'd1;
        end
    end

    always_ff @(posedge fb_clk or negedge rst_n) begin
        if (!rst_n) begin
            fb_gap_q   <= '0;
            fb_last_q  <= '0;
            fb_armed_q <= 1'b0;
        end else if (fb_pulse) begin
            fb_gap_q   <= 32'd1;
            fb_last_q  <= 32'(fb_period);
            fb_armed_q <= 1'b1;
        end else begin
            fb_gap_q <= fb_gap_q + 32'd1;
        end
    end

    AST_REF_GAP: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (cmp_pulse && ref_armed_q) |-> (ref_gap_q == ref_last_q)); // R1

    AST_REF_LEGAL: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ref_armed_q |-> (ref_period == REF_W'(RATIO_M0) || ref_period == REF_W'(RATIO_M1) ||
                         ref_period == REF_W'(RATIO_M2) || ref_period == REF_W'(RATIO_M3))); // R2

    AST_REF_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !cmp_pulse |-> $stable(ref_period)); // R6

    AST_CMP_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cmp_pulse |=> !cmp_pulse); // R7

    AST_FB_GAP: assert property (@(posedge fb_clk) disable iff (!rst_n)
        (fb_pulse && fb_armed_q) |-> (fb_gap_q == fb_last_q)); // R3

    AST_FB_FLOOR: assert property (@(posedge fb_clk) disable iff (!rst_n)
        fb_armed_q |-> (fb_period >= DIV_W'(MIN_DIV))); // R5

    AST_FB_HOLD: assert property (@(posedge fb_clk) disable iff (!rst_n)
        !fb_pulse |-> $stable(fb_period)); // R6

    AST_FB_SINGLE: assert property (@(posedge fb_clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse); // R7

endmodule

bind synth_div_chain sdc_checker #(
    .RATIO_M0 (RATIO_M0),
    .RATIO_M1 (RATIO_M1),
    .RATIO_M2 (RATIO_M2),
    .RATIO_M3 (RATIO_M3),
    .REF_W    (REF_W),
    .DIV_W    (DIV_W),
    .MIN_DIV  (MIN_DIV)
) u_chk (
    .ref_clk    (ref_clk),
    .fb_clk     (fb_clk),
    .rst_n      (rst_n),
    .cmp_pulse  (cmp_pulse),
    .fb_pulse   (fb_pulse),
    .ref_period (ref_period_w),
    .fb_period  (fb_period_w)
);

// File: tb/synth_div_chain_tb.sv
`timescale 1ns/100ps
module synth_div_chain_tb;

    logic        ref_clk = 1'b0;
    logic        fb_clk  = 1'b0;
    logic        rst_n   = 1'b0;
    logic [1:0]  mode    = 2'd3;
    logic [14:0] divisor = 15'h4005;
    logic        cmp_pulse, fb_pulse;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R8";
    bit    done = 1'b0;

    synth_div_chain u_dut (
        .ref_clk   (ref_clk),
        .fb_clk    (fb_clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .divisor   (divisor),
        .cmp_pulse (cmp_pulse),
        .fb_pulse  (fb_pulse)
    );

    // 50 MHz reference; feedback clock edges all fall on x.3 ns.
    always #10 ref_clk = ~ref_clk;
    initial begin
        #0.3;
        forever #6 fb_clk = ~fb_clk;
    end

    function automatic int ref_ratio(input logic [1:0] m);
        case (m)
            2'd0:    return 640;
            2'd1:    return 1024;
            default: return 512;
        endcase
    endfunction

    function automatic int fb_ratio(input logic [1:0] m, input logic [14:0] d);
        int v;
        v = int'(d);
        if (m == 2'd3) v = v % 16384;
        if (v < 2) v = 2;
        return v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
        end
    endtask

    // Reference-domain model: pulse when the period since the last pulse is used up.
    int r_since = 0, r_per = 0;
    bit r_first = 1'b1, r_exp = 1'b0;
    always begin
        @(posedge ref_clk);
        if (!rst_n) begin
            r_first = 1'b1;
            r_exp   = 1'b0;
        end else if (r_first || r_since == r_per - 1) begin
            r_exp   = 1'b1;
            r_per   = ref_ratio(mode);
            r_since = 0;
            r_first = 1'b0;
        end else begin
            r_exp = 1'b0;
            r_since++;
        end
        #1;
        if (!done) chk(cur_req, "cmp_pulse", int'(cmp_pulse), int'(r_exp));
    end

    // Feedback-domain model.
    int f_since = 0, f_per = 0;
    bit f_first = 1'b1, f_exp = 1'b0;
    always begin
        @(posedge fb_clk);
        if (!rst_n) begin
            f_first = 1'b1;
            f_exp   = 1'b0;
        end else if (f_first || f_since == f_per - 1) begin
            f_exp   = 1'b1;
            f_per   = fb_ratio(mode, divisor);
            f_since = 0;
            f_first = 1'b0;
        end else begin
            f_exp = 1'b0;
            f_since++;
        end
        #1;
        if (!done) chk(cur_req, "fb_pulse", int'(fb_pulse), int'(f_exp));
    end

    // Wait n reference cycles, then land on a .5 ns instant clear of all edges.
    task automatic run(input int n);
        repeat (n) @(posedge ref_clk);
        #2.5;
    endtask

    initial begin
        #50;
        chk("R8", "cmp_pulse in reset", int'(cmp_pulse), 0);
        chk("R8", "fb_pulse in reset", int'(fb_pulse), 0);
        #50.5;
        rst_n = 1'b1;
        run(4);
        cur_req = "R4";                       // mode 3, bit 14 dropped -> 5
        run(1200);
        cur_req = "R1";  mode = 2'd2; divisor = 15'd1000;
        run(1600);
        cur_req = "R2";  mode = 2'd1; divisor = 15'd300;
        run(2200);
        cur_req = "R2";  mode = 2'd0; divisor = 15'd777;
        run(1400);
        cur_req = "R5";  divisor = 15'd1;
        run(300);
        divisor = 15'd0;
        run(300);
        cur_req = "R6";  mode = 2'd3; divisor = 15'd40;
        run(100);
        mode = 2'd1; divisor = 15'd90;
        run(37);
        mode = 2'd0; divisor = 15'd2;
        run(1500);
        cur_req = "R3";  mode = 2'd0; divisor = 15'h4005;  // full 16389
        run(10000);
        cur_req = "R7";  mode = 2'd2; divisor = 15'd3;
        run(600);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #700000;
        done = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule